// File: doc/BRIEF.md
# Ping-Pong Sample Buffer Controller

This block writes a stream of incoming samples into memory, alternating between two equal-sized buffers. The controller always fills one of them and the processor owns the other. Each accepted sample produces one memory write in the same cycle it is presented. No processor action is needed for individual samples.

When the last slot of the current fill buffer is written, the two buffers exchange roles. The buffer that was just filled passes to the processor, and the other one becomes the new fill target, with its write address restarting at that buffer's base. In the same step a block interrupt is raised. The interrupt stays high until the processor acknowledges it. If another block completes before that acknowledge arrives, a sticky overrun flag is set, and the controller keeps alternating buffers anyway.

Two small state machines carry the control. The fill-role machine has the states FILL_LO (buffer 0 is filled, the processor owns buffer 1) and FILL_HI (the reverse). Its only transition, "swap", is taken on a block completion and goes from either state to the other. The interrupt machine has the states IRQ_IDLE and IRQ_PEND. Its transitions are:
- "raise": IRQ_IDLE to IRQ_PEND on a block completion.
- "clear": IRQ_PEND to IRQ_IDLE on an acknowledge with no completion in that cycle.
- "re-raise": IRQ_PEND to IRQ_PEND on a completion. This transition also sets the overrun flag when there is no acknowledge in that cycle.

Top module: `pingpong_dma`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `cpu_buf` is 1 (buffer 0 is the fill target), `blk_irq` is 0, `overrun` is 0, and the next accepted sample is written to address `BASE0`.
- R2: In every cycle with `smp_valid` high, `mem_we` is 1 in that same cycle, `mem_wdata` equals `smp_data`, and `mem_addr` equals the fill buffer's base plus the number of samples already written to that buffer. `mem_we` is 0 when `smp_valid` is 0.
- R3: Cycles with `smp_valid` low do not advance the fill position. The next write goes to the address that follows the last one written.
- R4: After `BUF_LEN` samples, `cpu_buf` toggles in the cycle after the last one, and the next sample is written to the other buffer's base (`BASE0` for buffer 0, `BASE1` for buffer 1).
- R5: `blk_irq` rises in the cycle after the last sample of a block.
- R6: `blk_irq` stays high until a cycle with `cpu_ack` high and no block completion, and it is low from the following cycle.
- R7: A block completion while `blk_irq` is high and `cpu_ack` is low sets `overrun` from the next cycle. `overrun` stays set until reset, and buffer swapping continues as usual.
- R8: If a block completion and `cpu_ack` occur in the same cycle, `blk_irq` stays high and `overrun` is not set.
- R9: `cpu_ack` while `blk_irq` is low has no effect on `blk_irq`, `overrun`, `cpu_buf`, or the fill position.
- R10: A reset in the middle of a block restores the R1 state, including clearing a set `overrun` and restarting the fill position at `BASE0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Sample value |
| cpu_ack | input | 1 | Processor acknowledge of the block interrupt |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| cpu_buf | output | 1 | Index of the buffer the processor currently owns |
| blk_irq | output | 1 | Block-complete interrupt, held until acknowledged |
| overrun | output | 1 | Sticky flag: a block finished before the previous one was acknowledged |

## Verification
The stream is applied in several patterns, and each pattern exposes a different class of fault:
- Back-to-back samples check the address stepping and the point where buffers swap.
- Samples separated by idle cycles show whether the fill position moves without a valid sample.
- Blocks are followed either by a prompt acknowledge or by none at all. The first case shows that the interrupt clears correctly. The second shows that it is held and that overrun is set only when a completion actually meets an unacknowledged interrupt.
- An acknowledge landing in the same cycle as a completion, and an acknowledge with nothing pending, catch a priority error in the interrupt machine.
- A reset in the middle of a block confirms that the fill position and the sticky flag both return to their starting values.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic {FILL_LO = 1'b0, FILL_HI = 1'b1} fill_e;
    typedef enum logic {IRQ_IDLE = 1'b0, IRQ_PEND = 1'b1} irq_e;
endpackage

// File: rtl/pp_fill_ctr.sv
module pp_fill_ctr #(
    parameter int BUF_LEN = 8,
    localparam int CNT_W  = $clog2(BUF_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(BUF_LEN - 1);

    assign last = adv && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (last) cnt <= '0;
        else if (adv)  cnt <= cnt + 1'b1;
    end

    // An idle cycle leaves the fill position where it was
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));
    // A block end brings the position back to the start
    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        last |=> (cnt == '0));
endmodule

// File: rtl/pp_role_fsm.sv
module pp_role_fsm
    import pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  swap,
    output fill_e tgt,
    output logic  cpu_buf
);
    fill_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            FILL_LO: if (swap) nxt = FILL_HI;
            FILL_HI: if (swap) nxt = FILL_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FILL_LO;
        else     state <= nxt;
    end

    always_comb begin
        tgt = state;
        unique case (state)
            FILL_LO: cpu_buf = 1'b1;
            FILL_HI: cpu_buf = 1'b0;
        endcase
    end

    assert_swap_R4: assert property (@(posedge clk) disable iff (rst)
        swap |=> (cpu_buf != $past(cpu_buf)));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !swap |=> $stable(cpu_buf));
endmodule

// File: rtl/pp_irq_fsm.sv
module pp_irq_fsm
    import pp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic blk_done,
    input  logic ack,
    output logic irq,
    output logic ovr
);
    irq_e state, nxt;
    logic ovr_q;

    always_comb begin
        nxt = state;
        unique case (state)
            IRQ_IDLE: if (blk_done) nxt = IRQ_PEND;
            IRQ_PEND: if (!blk_done && ack) nxt = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= IRQ_IDLE;
            ovr_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == IRQ_PEND && blk_done && !ack) ovr_q <= 1'b1;
        end
    end

    always_comb begin
        ovr = ovr_q;
        unique case (state)
            IRQ_IDLE: irq = 1'b0;
            IRQ_PEND: irq = 1'b1;
        endcase
    end

    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (rst)
        blk_done |=> irq);
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq);
    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && ack && !blk_done) |=> !irq);
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovr |=> ovr);
    assert_ovr_set_R7: assert property (@(posedge clk) disable iff (rst)
        (irq && blk_done && !ack) |=> ovr);
    assert_no_ovr_on_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (!ovr && ack) |=> !ovr);
endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
    import pp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 12,
    parameter int BUF_LEN = 8,
    parameter int BASE0   = 'h000,
    parameter int BASE1   = 'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              cpu_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              cpu_buf,
    output logic              blk_irq,
    output logic              overrun
);
    localparam int CNT_W = $clog2(BUF_LEN);
    localparam logic [ADDR_W-1:0] B0 = ADDR_W'(BASE0);
    localparam logic [ADDR_W-1:0] B1 = ADDR_W'(BASE1);

    logic [CNT_W-1:0] cnt;
    logic             last;
    fill_e            tgt;
    logic [ADDR_W-1:0] base;

    pp_fill_ctr #(.BUF_LEN(BUF_LEN)) u_ctr (
        .clk(clk), .rst(rst), .adv(smp_valid), .cnt(cnt), .last(last)
    );

    pp_role_fsm u_role (
        .clk(clk), .rst(rst), .swap(last), .tgt(tgt), .cpu_buf(cpu_buf)
    );

    pp_irq_fsm u_irq (
        .clk(clk), .rst(rst), .blk_done(last), .ack(cpu_ack),
        .irq(blk_irq), .ovr(overrun)
    );

    always_comb begin
        unique case (tgt)
            FILL_LO: base = B0;
            FILL_HI: base = B1;
        endcase
    end

    assign mem_we    = smp_valid;
    assign mem_wdata = smp_data;
    assign mem_addr  = base + ADDR_W'(cnt);

    // A write never lands inside the buffer the processor owns
    assert_own_excl_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (cpu_buf ? (mem_addr < B1 || mem_addr >= B1 + ADDR_W'(BUF_LEN))
                            : (mem_addr < B0 || mem_addr >= B0 + ADDR_W'(BUF_LEN))));
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cpu_buf && !blk_irq && !overrun));
endmodule

// File: tb/test_pingpong_dma.sv
module test_pingpong_dma;
    localparam int DW = 16, AW = 12, LEN = 8, B0 = 'h000, B1 = 'h100;

    logic clk = 0, rst = 1, smp_valid = 0, cpu_ack = 0;
    logic [DW-1:0] smp_data = '0;
    logic mem_we, cpu_buf, blk_irq, overrun;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    pingpong_dma #(.DATA_W(DW), .ADDR_W(AW), .BUF_LEN(LEN), .BASE0(B0), .BASE1(B1))
        i_pingpong_dma (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    string phase = "R1";
    logic [AW+DW-1:0] exp_q[$];

    // reference model (state after the last edge)
    int  m_cnt = 0;
    bit  m_tgt = 0, m_irq = 0, m_ovr = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, tag, act, exp);
        end
    endtask

    // monitor: pops expected writes
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) check("R2 unexpected write", 1, 0);
            else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                check("R2 addr", int'(mem_addr), int'(e[AW+DW-1:DW]));
                check("R2 data", int'(mem_wdata), int'(e[DW-1:0]));
            end
        end else if (!rst) check("R2 we low when idle", int'(mem_we), 0);
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1; smp_valid = 0; cpu_ack = 0;
        @(posedge clk); #1;
        rst = 0;
        m_cnt = 0; m_tgt = 0; m_irq = 0; m_ovr = 0;
        @(negedge clk);
        check("cpu_buf", int'(cpu_buf), 1);
        check("blk_irq", int'(blk_irq), 0);
        check("overrun", int'(overrun), 0);
    endtask

    // driver: one cycle of stimulus, expected write pushed, flags checked
    task automatic cyc(input bit v, input logic [DW-1:0] d, input bit a);
        bit done;
        @(posedge clk); #1;
        smp_valid = v; smp_data = d; cpu_ack = a;
        if (v) exp_q.push_back({AW'(m_tgt ? B1 : B0) + AW'(m_cnt), d});
        @(negedge clk);
        check("cpu_buf", int'(cpu_buf), int'(!m_tgt));
        check("blk_irq", int'(blk_irq), int'(m_irq));
        check("overrun", int'(overrun), int'(m_ovr));
        done = v && (m_cnt == LEN - 1);
        if (v) m_cnt = done ? 0 : m_cnt + 1;
        if (done) begin
            m_tgt = !m_tgt;
            if (m_irq && !a) m_ovr = 1;
            m_irq = 1;
        end else if (a) m_irq = 0;
    endtask

    task automatic block(input int seed, input bit ack_last);
        for (int i = 0; i < LEN; i++) cyc(1, DW'(seed + i), (i == LEN - 1) ? ack_last : 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0);
    endtask

    bit finished = 0;
    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        phase = "R1"; do_reset();
        cyc(1, 16'hA000, 0);               // first write at BASE0 (R1)
        phase = "R3";                      // gaps do not advance the address
        idle(2); cyc(1, 16'hA001, 0); idle(3); cyc(1, 16'hA002, 0);
        phase = "R2";                      // back-to-back fill to block end
        for (int i = 3; i < LEN; i++) cyc(1, DW'(16'hA000 + i), 0);
        phase = "R4";                      // swap visible, next write at BASE1
        cyc(1, 16'hB000, 0);
        phase = "R5";                      // interrupt held while idle
        idle(3);
        phase = "R6";                      // acknowledge clears it
        cyc(0, '0, 1); idle(2);
        phase = "R9";                      // acknowledge with nothing pending
        cyc(0, '0, 1); cyc(1, 16'hB001, 1); idle(1);
        for (int i = 2; i < LEN; i++) cyc(1, DW'(16'hB000 + i), 0);
        phase = "R7";                      // second block without acknowledge
        block(16'hC000, 0); idle(2); block(16'hC100, 1); idle(2);
        phase = "R10";                     // reset mid-block clears overrun
        cyc(1, 16'hD000, 0); cyc(1, 16'hD001, 0);
        do_reset();
        cyc(1, 16'hD100, 0);
        for (int i = 1; i < LEN; i++) cyc(1, DW'(16'hD100 + i), 0);
        phase = "R8";                      // ack coinciding with completion
        block(16'hE000, 1); idle(2);
        cyc(0, '0, 1); idle(2);
        check("R2 queue drained", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule